// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status Collector

This block gathers the one-cycle event pulses that an SD/MMC host produces (from its command engine, data path, FIFO and card-detect logic). Each pulse sets a sticky bit in a raw status register. Software clears a raw bit by writing a one to it. A mask register selects which raw bits may raise the interrupt. The AND of the raw and mask registers forms the masked status. A single interrupt request line is asserted when the global interrupt enable is on and any masked bit is set.

Alongside the interrupt, the block computes two summary flags straight from the raw status. One flags any bit of the error group; the other flags any bit of the completion group. A two-bit register select drives both a write port and a combinational readback port, so control, mask, raw and masked status can all be read.

Top module: `sdmmc_irq_status`

## Requirements
- R1: After reset the raw, mask and control registers are zero, and the interrupt request, any_error and any_done are low.
- R2: A strobe on an implemented event input sets the matching raw bit at the next clock edge. The bit then stays set until software clears it. Implemented bits: 1 response error, 2 command done, 3 data over, 4 transmit request, 5 receive request, 6 response CRC error, 7 data CRC error, 8 response timeout, 9 data timeout, 10 voltage switch done, 11 FIFO under/overrun, 12 hardware locked, 13 start bit error, 14 auto command done, 15 end bit error, 16 SDIO card interrupt, 30 card inserted, 31 card removed.
- R3: A write to the raw register (select 2) clears every raw bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event strobe and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Raw bits 0 and 17 to 29 always read 0, whatever strobes arrive.
- R6: A write to the mask register (select 1) stores all 32 data bits, and they read back unchanged.
- R7: The masked status (readback select 3) equals the raw status ANDed with the mask.
- R8: The control register (select 0) stores only bit 4, the global interrupt enable; all its other bits read 0.
- R9: The interrupt request is high exactly when control bit 4 is set and at least one masked status bit is 1.
- R10: any_error is high exactly when at least one raw bit among 1, 6, 7, 8, 9, 11, 12, 13, 15 is set.
- R11: any_done is high exactly when at least one raw bit among 2, 3, 10, 14 is set.
- R12: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 32 | One-cycle event pulses, one per raw bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 mask, 2 raw (write-one-to-clear), 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Readback select: 0 control, 1 mask, 2 raw, 3 masked status |
| rd_data | output | 32 | Combinational readback of the selected register |
| masked_stat | output | 32 | Raw status ANDed with mask |
| irq | output | 1 | Interrupt request |
| any_error | output | 1 | Some error-group raw bit is set |
| any_done | output | 1 | Some done-group raw bit is set |

## Verification
The assertions assume only that the inputs carry known values while out of reset. Strobes may arrive on any bit, including the unimplemented ones, and in any cycle, including one that writes the same bit. The stimulus keeps every input at a defined value on every cycle. It mixes random event patterns, of both sparse and dense density, with random writes to all four select codes, so that the set-versus-clear collision and the writes to select 3 happen many times. It also forces directed cases.

// File: rtl/sdmmc_irq_pkg.sv
`timescale 1ns/1ps
package sdmmc_irq_pkg;
  localparam int STAT_W = 32;
  localparam int EN_POS = 4;
  localparam logic [STAT_W-1:0] LIVE_BITS = 32'hC001_FFFE;
  localparam logic [STAT_W-1:0] ERR_GROUP = 32'h0000_BBC2;
  localparam logic [STAT_W-1:0] DONE_GROUP = 32'h0000_440C;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_RAW   = 2'd2,
    SEL_MSTAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sdmmc_irq_raw.sv
`timescale 1ns/1ps
module sdmmc_irq_raw #(
  parameter int W = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] raw_q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (LIVE[b]) begin : g_live
      logic nxt;
      logic upd;
      always_comb begin
        upd = set_vec[b] | clr_vec[b];
        nxt = set_vec[b] | (raw_q[b] & ~clr_vec[b]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   raw_q[b] <= 1'b0;
        else if (upd) raw_q[b] <= nxt;
      end
    end else begin : g_tied
      assign raw_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/sdmmc_irq_cfg.sv
`timescale 1ns/1ps
module sdmmc_irq_cfg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         ctrl_we,
  input  logic [W-1:0] wdata,
  input  logic         en_bit,
  output logic [W-1:0] mask_q,
  output logic         glob_en_q
);
  logic [W-1:0] mask_nxt;
  logic         en_nxt;

  always_comb begin
    mask_nxt = wdata;
    en_nxt   = en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glob_en_q <= 1'b0;
    else if (ctrl_we) glob_en_q <= en_nxt;
  end
endmodule

// File: rtl/sdmmc_irq_out.sv
`timescale 1ns/1ps
module sdmmc_irq_out #(
  parameter int W = 32,
  parameter int EN_BIT = 4,
  parameter logic [W-1:0] ERR_M = '0,
  parameter logic [W-1:0] DONE_M = '0
) (
  input  logic [W-1:0] raw_q,
  input  logic [W-1:0] mask_q,
  input  logic         glob_en_q,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] masked,
  output logic         irq,
  output logic         any_err,
  output logic         any_done
);
  import sdmmc_irq_pkg::*;
  logic [W-1:0] ctrl_view;

  always_comb begin
    masked   = raw_q & mask_q;
    irq      = glob_en_q & (|masked);
    any_err  = |(raw_q & ERR_M);
    any_done = |(raw_q & DONE_M);
    ctrl_view = '0;
    ctrl_view[EN_BIT] = glob_en_q;
    unique case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data = ctrl_view;
      SEL_MASK: rd_data = mask_q;
      SEL_RAW:  rd_data = raw_q;
      default:  rd_data = masked;
    endcase
  end
endmodule

// File: rtl/sdmmc_irq_status.sv
`timescale 1ns/1ps
module sdmmc_irq_status
  import sdmmc_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_strobe,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] masked_stat,
  output logic         irq,
  output logic         any_error,
  output logic         any_done
);
  localparam logic [W-1:0] LIVE_W = W'(LIVE_BITS);
  localparam logic [W-1:0] ERR_W  = W'(ERR_GROUP);
  localparam logic [W-1:0] DONE_W = W'(DONE_GROUP);

  logic         mask_we, ctrl_we, raw_we;
  logic [W-1:0] clr_vec, raw_q, mask_q;
  logic         glob_en_q;

  always_comb begin
    mask_we = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
    ctrl_we = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    raw_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_RAW);
    clr_vec = raw_we ? wr_data : '0;
  end

  sdmmc_irq_raw #(.W(W), .LIVE(LIVE_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_strobe), .clr_vec(clr_vec),
    .raw_q(raw_q)
  );

  sdmmc_irq_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .ctrl_we(ctrl_we),
    .wdata(wr_data), .en_bit(wr_data[EN_POS]), .mask_q(mask_q),
    .glob_en_q(glob_en_q)
  );

  sdmmc_irq_out #(.W(W), .EN_BIT(EN_POS), .ERR_M(ERR_W), .DONE_M(DONE_W)) u_out (
    .raw_q(raw_q), .mask_q(mask_q), .glob_en_q(glob_en_q), .rd_sel(rd_sel),
    .rd_data(rd_data), .masked(masked_stat), .irq(irq),
    .any_err(any_error), .any_done(any_done)
  );
endmodule

// File: rtl/sdmmc_irq_status_chk.sv
`timescale 1ns/1ps
module sdmmc_irq_status_chk
  import sdmmc_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_strobe,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] raw_q,
  input logic [31:0] mask_q,
  input logic        glob_en_q,
  input logic [31:0] masked_stat,
  input logic        irq
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_strobe & LIVE_BITS) |=> ((raw_q & $past(evt_strobe & LIVE_BITS)) == $past(evt_strobe & LIVE_BITS)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> ((raw_q & $past(wr_data & ~evt_strobe)) == 32'd0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == 2'd2) && evt_strobe == 32'd0) |=> $stable(raw_q));

  assert_dead_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~LIVE_BITS) == 32'd0);

  assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (mask_q == $past(wr_data)));

  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    masked_stat == (raw_q & mask_q));

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (glob_en_q && (raw_q & mask_q) != 32'd0));

  assert_sel3_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(mask_q) && $stable(glob_en_q)));
endmodule

bind sdmmc_irq_status sdmmc_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .raw_q(raw_q), .mask_q(mask_q),
  .glob_en_q(glob_en_q), .masked_stat(masked_stat), .irq(irq)
);

// File: tb/tb_sdmmc_irq_status.sv
`timescale 1ns/1ps
module tb_sdmmc_irq_status;
  localparam logic [31:0] M_LIVE = 32'hC001_FFFE;
  localparam logic [31:0] M_ERR  = 32'h0000_BBC2;
  localparam logic [31:0] M_DONE = 32'h0000_440C;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] evt_strobe, wr_data, rd_data, masked_stat;
  logic wr_en, irq, any_error, any_done;
  logic [1:0] wr_sel, rd_sel;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_raw, m_mask;
  logic m_en;

  always #2 clk = ~clk;

  sdmmc_irq_status dut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .masked_stat(masked_stat), .irq(irq), .any_error(any_error), .any_done(any_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_raw(logic [31:0] raw, logic [31:0] ev,
                                           logic we, logic [1:0] sel, logic [31:0] d);
    logic [31:0] clr = (we && sel == 2'd2) ? d : 32'd0;
    return ((raw & ~clr) | ev) & M_LIVE;
  endfunction

  task automatic read_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    rd_sel = sel;
    #0.2;
    chk(req, rd_data, exp);
  endtask

  task automatic check_all();
    logic [31:0] ms = m_raw & m_mask;
    chk("R7 masked_stat", masked_stat, ms);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_en && ms != 0});
    chk("R10 any_error", {31'd0, any_error}, {31'd0, (m_raw & M_ERR) != 0});
    chk("R11 any_done", {31'd0, any_done}, {31'd0, (m_raw & M_DONE) != 0});
    read_chk(2'd0, {27'd0, m_en, 4'd0}, "R8 ctrl readback");
    read_chk(2'd1, m_mask, "R6 mask readback");
    read_chk(2'd2, m_raw, "R2 raw readback");
    read_chk(2'd3, ms, "R7 masked readback");
  endtask

  task automatic step(input logic [31:0] ev, input logic we, input logic [1:0] sel,
                      input logic [31:0] d);
    evt_strobe = ev; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    m_raw = next_raw(m_raw, ev, we, sel, d);
    if (we && sel == 2'd1) m_mask = d;
    if (we && sel == 2'd0) m_en = d[4];
    #1;
    evt_strobe = '0; wr_en = 1'b0;
    check_all();
  endtask

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; evt_strobe = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    m_raw = '0; m_mask = '0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 any_error", {31'd0, any_error}, 32'd0);
    chk("R1 any_done", {31'd0, any_done}, 32'd0);
    read_chk(2'd0, 32'd0, "R1 ctrl");
    read_chk(2'd1, 32'd0, "R1 mask");
    read_chk(2'd2, 32'd0, "R1 raw");
    @(negedge clk);
    // R5: strobes on dead bits only
    step(32'h3FFE_0001, 1'b0, 2'd0, 32'd0);
    // R8: all-ones control write keeps only bit 4
    step(32'd0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    // R6: mask write
    step(32'd0, 1'b1, 2'd1, 32'hA5A5_5A5A);
    // R2/R10: single error event (response timeout, bit 8)
    step(32'h0000_0100, 1'b0, 2'd0, 32'd0);
    // R11: command done (bit 2), mask fully open
    step(32'h0000_0004, 1'b1, 2'd1, 32'hFFFF_FFFF);
    // R4: set and clear on bit 2 together; clear bit 8 alone
    step(32'h0000_0004, 1'b1, 2'd2, 32'h0000_0104);
    // R12: select 3 write changes nothing
    step(32'd0, 1'b1, 2'd3, 32'h0000_0000);
    // R3: clear everything
    step(32'd0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    // R9: enable off with pending masked bit
    step(32'hC000_0000, 1'b1, 2'd0, 32'd0);
    step(32'd0, 1'b1, 2'd0, 32'h0000_0010);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev;
      logic [31:0] d;
      logic we;
      ev = ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) ev = '0;
      we = ($urandom_range(0, 2) == 0);
      d = ($urandom_range(0, 3) == 0) ? ev : $urandom;
      step(ev, we, 2'($urandom_range(0, 3)), d);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule